// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Selective Invalidation

This block is a small fully associative translation cache that sits in front of a page-table walker. Every line holds a 7-bit address-space tag, a 20-bit virtual page number for a 4 KiB page, a 20-bit physical frame number and three permission bits. A requester presents an address-space tag and a 32-bit virtual address. One cycle later the block answers with a hit carrying the frame and permissions, a miss, or a stall.

After a miss the walker resolves the translation and writes it back through the fill port. Software-side maintenance arrives as a 32-bit invalidation command word. The command can drop everything, or only the lines of one address space. It can also narrow the drop to a 4 MiB section or a 16 KiB group of virtual addresses.

A configuration input limits how many lines take part in lookups and replacement. A second configuration input decides whether hits may be served while a miss is still waiting for its fill.

Top module: `asid_tlb`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rsp_valid` is low. Every line is invalid, the replacement pointer is at line 0 and no miss is outstanding.
- R2: A lookup accepted at a clock edge produces `rsp_valid` after that same edge. The lookup hits when an active valid line holds the same address-space tag and `lk_vaddr[31:12]`. A hit returns that line's frame and permissions, with `perm[2]` readable, `perm[1]` writable and `perm[0]` non-secure. When several lines match, the lowest-numbered line wins.
- R3: A served lookup that misses returns `rsp_hit`=0 with the frame and permissions at zero, and it marks a miss outstanding. A fill clears the outstanding miss unless a served miss happens in the same cycle.
- R4: A fill whose tag and page already sit in an active valid line rewrites that line in place. Otherwise the fill writes the line at the round-robin pointer, which then moves to the next active line and wraps to 0. A pointer at or beyond the active count is treated as 0.
- R5: The active count is `min(cfg_lines, N_LINES)`. Lines at or above it never hit and are never written. With a count of 0, fills are dropped.
- R6: A flush command whose bit 31 is 0 and whose mode field `[1:0]` is 0 invalidates every line.
- R7: With bit 31 set, only lines whose address-space tag equals command bits `[30:24]` are invalidated, and this qualifier combines with any address mode.
- R8: Mode 2 invalidates lines whose page bits `[19:10]` (virtual address bits 31..22) equal command bits `[19:10]`.
- R9: Mode 3 invalidates lines whose page bits `[19:2]` (virtual address bits 31..14) equal command bits `[19:2]`.
- R10: Mode 1 invalidates nothing: every line stays visible to later lookups.
- R11: A lookup in the same cycle as a flush sees the lines as they were before the flush. A fill in the same cycle as a flush leaves its written line valid.
- R12: While a miss is outstanding, every lookup returns `rsp_stall`=1 and no hit when `cfg_hum` is 0. When `cfg_hum` is 1, lookups that hit are served and only misses stall. A stalled lookup changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lines | input | 6 | Requested number of active lines |
| cfg_hum | input | 1 | Serve hits while a miss is outstanding |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space tag |
| lk_vaddr | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_stall | output | 1 | Lookup was not served; retry |
| rsp_pfn | output | 20 | Frame number on hit |
| rsp_perm | output | 3 | {readable, writable, non-secure} on hit |
| fill_valid | input | 1 | Write a translation |
| fill_asid | input | 7 | Fill address-space tag |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pfn | input | 20 | Fill frame number |
| fill_perm | input | 3 | Fill permissions |
| flush_valid | input | 1 | Apply an invalidation command |
| flush_cmd | input | 32 | Invalidation command word |

## Verification
The bench builds the block with `N_LINES` = 8 so that replacement wrap-around and eviction occur after a handful of fills. That size also lets `cfg_lines` values of 0, 2, 6 and 63 fall below, inside and above the physical line count. Address-space tags and pages are drawn from small pools. As a result, section and group flushes, same-tag rewrites, same-cycle flush/lookup and flush/fill collisions, and hit-under-miss stalls come up often in the random phase.

// File: rtl/tlbq_pkg.sv
package tlbq_pkg;

    localparam int ASID_W = 7;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int CFG_W  = 6;
    localparam int PG_SH  = 12;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
    } tag_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ns;
    } perm_t;

    typedef struct packed {
        tag_t             tag;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } ent_t;

    typedef enum logic [1:0] {
        AM_EVERY = 2'd0,
        AM_NONE  = 2'd1,
        AM_SECT  = 2'd2,
        AM_GRP   = 2'd3
    } amode_e;

    typedef struct packed {
        logic              by_asid;
        logic [ASID_W-1:0] asid;
        amode_e            mode;
        logic [VPN_W-1:0]  key;
    } inval_t;

    function automatic inval_t decode_inval(input logic [31:0] w);
        inval_t d;
        d.by_asid = w[31];
        d.asid    = w[30:24];
        d.mode    = amode_e'(w[1:0]);
        d.key     = w[19:0];
        return d;
    endfunction

    function automatic logic inval_match(input inval_t d, input tag_t t);
        logic sp_ok;
        logic ad_ok;
        sp_ok = !d.by_asid || (t.asid == d.asid);
        case (d.mode)
            AM_EVERY: ad_ok = 1'b1;
            AM_SECT:  ad_ok = (t.vpn[19:10] == d.key[19:10]);
            AM_GRP:   ad_ok = (t.vpn[19:2] == d.key[19:2]);
            default:  ad_ok = 1'b0;
        endcase
        return sp_ok && ad_ok;
    endfunction

endpackage

// File: rtl/tlbq_line.sv
module tlbq_line
    import tlbq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   act,
    input  tag_t   probe_tag,
    input  tag_t   fill_tag,
    input  logic   inv_en,
    input  inval_t inv,
    input  logic   wr_en,
    input  ent_t   wr_ent,
    output logic   probe_hit,
    output logic   fill_hit,
    output logic   valid_q,
    output ent_t   ent_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ent_q   <= '0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            ent_q   <= wr_ent;
        end else if (inv_en && valid_q && inval_match(inv, ent_q.tag)) begin
            valid_q <= 1'b0;
        end
    end

    assign probe_hit = act && valid_q && (ent_q.tag == probe_tag);
    assign fill_hit  = act && valid_q && (ent_q.tag == fill_tag);

    // R11: a written line is valid afterwards even under a concurrent flush
    a_r11_fill_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q);

    // R5: an inactive line never reports a match
    a_r5_inactive_quiet: assert property (@(posedge clk) disable iff (rst)
        !act |-> !(probe_hit || fill_hit));

endmodule

// File: rtl/tlbq_victim.sv
module tlbq_victim #(
    parameter int N_LINES = 32,
    parameter int IDX_W   = 5,
    parameter int CW      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    act_n,
    input  logic             adv,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_ok
);

    logic [IDX_W-1:0] ptr_q;
    logic [CW-1:0]    vic_ext;
    logic [CW-1:0]    nxt_ext;

    always_comb begin
        vic_ok  = (act_n != '0);
        vic_ext = (CW'(ptr_q) < act_n) ? CW'(ptr_q) : '0;
        nxt_ext = vic_ext + CW'(1);
        vic_idx = IDX_W'(vic_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (adv && vic_ok) begin
            ptr_q <= (nxt_ext >= act_n) ? '0 : IDX_W'(nxt_ext);
        end
    end

    // R4: after an advance the pointer stays inside the active range
    a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        (adv && vic_ok) |=> (CW'(ptr_q) < $past(act_n)));

    // R1: the pointer starts at line 0
    a_r1_ptr_reset: assert property (@(posedge clk)
        rst |=> (ptr_q == '0));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlbq_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CFG_W-1:0]     cfg_lines,
    input  logic                 cfg_hum,
    input  logic                 lk_valid,
    input  logic [ASID_W-1:0]    lk_asid,
    input  logic [31:0]          lk_vaddr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_stall,
    output logic [PFN_W-1:0]     rsp_pfn,
    output logic [2:0]           rsp_perm,
    input  logic                 fill_valid,
    input  logic [ASID_W-1:0]    fill_asid,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PFN_W-1:0]     fill_pfn,
    input  logic [2:0]           fill_perm,
    input  logic                 flush_valid,
    input  logic [31:0]          flush_cmd
);

    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam int CW    = (IDX_W + 1 > CFG_W) ? IDX_W + 1 : CFG_W;

    logic [CW-1:0]      cfg_ext;
    logic [CW-1:0]      act_n;
    logic [N_LINES-1:0] line_act;
    logic [N_LINES-1:0] hit_vec;
    logic [N_LINES-1:0] fm_vec;
    logic [N_LINES-1:0] fm_first;
    logic [N_LINES-1:0] wr_vec;
    logic [N_LINES-1:0] line_valid;
    ent_t               ent_arr [N_LINES];

    tag_t   probe_tag;
    tag_t   fill_tag;
    ent_t   fill_ent;
    inval_t inv;

    logic             any_hit;
    logic             any_fm;
    ent_t             sel_ent;
    logic             pend_q;
    logic             served;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_ok;
    logic             adv;

    assign cfg_ext = CW'(cfg_lines);
    assign act_n   = (cfg_ext > CW'(N_LINES)) ? CW'(N_LINES) : cfg_ext;

    assign probe_tag     = '{asid: lk_asid, vpn: lk_vaddr[31:PG_SH]};
    assign fill_tag      = '{asid: fill_asid, vpn: fill_vpn};
    assign fill_ent.tag  = fill_tag;
    assign fill_ent.pfn  = fill_pfn;
    assign fill_ent.perm = perm_t'(fill_perm);
    assign inv           = decode_inval(flush_cmd);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign line_act[g] = (CW'(g) < act_n);
        assign wr_vec[g]   = fill_valid &&
                             (any_fm ? fm_first[g] : (vic_ok && (vic_idx == IDX_W'(g))));
        tlbq_line u_line (
            .clk       (clk),
            .rst       (rst),
            .act       (line_act[g]),
            .probe_tag (probe_tag),
            .fill_tag  (fill_tag),
            .inv_en    (flush_valid),
            .inv       (inv),
            .wr_en     (wr_vec[g]),
            .wr_ent    (fill_ent),
            .probe_hit (hit_vec[g]),
            .fill_hit  (fm_vec[g]),
            .valid_q   (line_valid[g]),
            .ent_q     (ent_arr[g])
        );
    end

    // lowest-numbered matching line wins
    always_comb begin
        sel_ent = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_ent = ent_arr[i];
        end
        any_hit = |hit_vec;
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        fm_first = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (fm_vec[i] && !found) begin
                fm_first[i] = 1'b1;
                found       = 1'b1;
            end
        end
        any_fm = found;
    end

    assign adv = fill_valid && !any_fm;

    tlbq_victim #(
        .N_LINES (N_LINES),
        .IDX_W   (IDX_W),
        .CW      (CW)
    ) u_victim (
        .clk     (clk),
        .rst     (rst),
        .act_n   (act_n),
        .adv     (adv),
        .vic_idx (vic_idx),
        .vic_ok  (vic_ok)
    );

    assign served = lk_valid && !(pend_q && (!cfg_hum || !any_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_stall <= 1'b0;
            rsp_pfn   <= '0;
            rsp_perm  <= '0;
        end else begin
            if (served && !any_hit) pend_q <= 1'b1;
            else if (fill_valid)    pend_q <= 1'b0;
            rsp_valid <= lk_valid;
            rsp_stall <= lk_valid && !served;
            rsp_hit   <= served && any_hit;
            rsp_pfn   <= (served && any_hit) ? sel_ent.pfn : '0;
            rsp_perm  <= (served && any_hit) ? 3'(sel_ent.perm) : '0;
        end
    end

    // R2: every lookup is answered after the next edge
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R3: a served miss leaves a miss outstanding
    a_r3_miss_pending: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && !rsp_stall) |-> pend_q);

    // R12: without an outstanding miss nothing stalls
    a_r12_no_idle_stall: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !pend_q) |=> (rsp_valid && !rsp_stall));

    // R12: a stall never carries a hit
    a_r12_stall_no_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_stall |-> (rsp_valid && !rsp_hit));

    // R6: an unqualified match-all flush empties every line
    a_r6_flush_all: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !flush_cmd[31] && (flush_cmd[1:0] == 2'd0) && !fill_valid)
        |=> (line_valid == '0));

    // R5: no hit with zero active lines
    a_r5_zero_active: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> ($past(act_n) != '0));

    // R1: no response right after reset
    a_r1_quiet_reset: assert property (@(posedge clk)
        rst |=> !rsp_valid);

endmodule

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;

    localparam int  NL      = 8;
    localparam time CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  cfg_lines;
    logic        cfg_hum;
    logic        lk_valid;
    logic [6:0]  lk_asid;
    logic [31:0] lk_vaddr;
    logic        rsp_valid, rsp_hit, rsp_stall;
    logic [19:0] rsp_pfn;
    logic [2:0]  rsp_perm;
    logic        fill_valid;
    logic [6:0]  fill_asid;
    logic [19:0] fill_vpn, fill_pfn;
    logic [2:0]  fill_perm;
    logic        flush_valid;
    logic [31:0] flush_cmd;

    always #(CLK_PER / 2) clk = ~clk;

    asid_tlb #(.N_LINES(NL)) dut_i (
        .clk(clk), .rst(rst), .cfg_lines(cfg_lines), .cfg_hum(cfg_hum),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_stall(rsp_stall),
        .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_valid(flush_valid), .flush_cmd(flush_cmd)
    );

    typedef struct {
        bit          hit;
        bit          stall;
        logic [19:0] pfn;
        logic [2:0]  perm;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;

    // reference state
    bit          m_v    [NL];
    logic [6:0]  m_asid [NL];
    logic [19:0] m_vpn  [NL];
    logic [19:0] m_pfn  [NL];
    logic [2:0]  m_perm [NL];
    int          m_ptr;
    bit          m_pend;

    function automatic int m_act();
        return (int'(cfg_lines) > NL) ? NL : int'(cfg_lines);
    endfunction

    function automatic int m_find(input logic [6:0] a, input logic [19:0] v);
        for (int i = 0; i < m_act(); i++)
            if (m_v[i] && m_asid[i] == a && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic bit m_inv(input logic [31:0] c, input int i);
        bit sp_ok;
        bit ad_ok;
        sp_ok = !c[31] || (m_asid[i] == c[30:24]);
        case (c[1:0])
            2'd0: ad_ok = 1'b1;
            2'd2: ad_ok = (m_vpn[i][19:10] == c[19:10]);
            2'd3: ad_ok = (m_vpn[i][19:2] == c[19:2]);
            default: ad_ok = 1'b0;
        endcase
        return sp_ok && ad_ok;
    endfunction

    task automatic step(input bit lv, input logic [6:0] la, input logic [31:0] va,
                        input bit fv, input logic [6:0] fa, input logic [19:0] fvp,
                        input logic [19:0] fpf, input logic [2:0] fpm,
                        input bit xv, input logic [31:0] xc, input string tag);
        exp_t e;
        int   li;
        int   tgt;
        bit   srv_miss;
        lk_valid = lv; lk_asid = la; lk_vaddr = va;
        fill_valid = fv; fill_asid = fa; fill_vpn = fvp; fill_pfn = fpf; fill_perm = fpm;
        flush_valid = xv; flush_cmd = xc;
        srv_miss = 1'b0;
        if (lv) begin
            li = m_find(la, va[31:12]);
            e.tag   = tag;
            e.stall = m_pend && (!cfg_hum || li < 0);
            e.hit   = !e.stall && li >= 0;
            e.pfn   = e.hit ? m_pfn[li] : 20'd0;
            e.perm  = e.hit ? m_perm[li] : 3'd0;
            srv_miss = !e.stall && li < 0;
            sb_q.push_back(e);
        end
        tgt = -1;
        if (fv) begin
            tgt = m_find(fa, fvp);
            if (tgt < 0 && m_act() > 0) begin
                tgt   = (m_ptr < m_act()) ? m_ptr : 0;
                m_ptr = (tgt + 1 >= m_act()) ? 0 : tgt + 1;
            end
        end
        @(posedge clk);
        if (xv)
            for (int i = 0; i < NL; i++)
                if (i != tgt && m_v[i] && m_inv(xc, i)) m_v[i] = 1'b0;
        if (tgt >= 0) begin
            m_v[tgt] = 1'b1; m_asid[tgt] = fa; m_vpn[tgt] = fvp;
            m_pfn[tgt] = fpf; m_perm[tgt] = fpm;
        end
        if (srv_miss) m_pend = 1'b1;
        else if (fv)  m_pend = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0; flush_valid = 1'b0;
    endtask

    task automatic look(input logic [6:0] a, input logic [31:0] va, input string tag);
        step(1, a, va, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input logic [6:0] a, input logic [19:0] v, input logic [19:0] p,
                        input logic [2:0] pm);
        step(0, 0, 0, 1, a, v, p, pm, 0, 0, "fill");
    endtask

    task automatic flush(input logic [31:0] c);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, c, "flush");
    endtask

    // monitor: compare each response against the oldest expectation
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            exp_t e;
            n_vec++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected response act=%0b exp=none", rsp_hit);
            end else begin
                e = sb_q.pop_front();
                if (rsp_hit !== e.hit || rsp_stall !== e.stall ||
                    rsp_pfn !== e.pfn || rsp_perm !== e.perm) begin
                    n_fail++;
                    $display("FAIL %s: act hit=%0b stall=%0b pfn=%h perm=%b exp hit=%0b stall=%0b pfn=%h perm=%b",
                             e.tag, rsp_hit, rsp_stall, rsp_pfn, rsp_perm,
                             e.hit, e.stall, e.pfn, e.perm);
                end
            end
        end
    end

    function automatic logic [31:0] va_of(input logic [19:0] v);
        return {v, 12'h000};
    endfunction

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: act=expired exp=done");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
                $finish;
            end
        join_none

        rst = 1'b1; cfg_lines = 6'd6; cfg_hum = 1'b1;
        lk_valid = 0; lk_asid = 0; lk_vaddr = 0;
        fill_valid = 0; fill_asid = 0; fill_vpn = 0; fill_pfn = 0; fill_perm = 0;
        flush_valid = 0; flush_cmd = 0;
        for (int i = 0; i < NL; i++) begin
            m_v[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
        end
        m_ptr = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rsp_valid act=%0b exp=0", rsp_valid);
        end

        // R1 / R3: empty after reset, miss sets pending, fill clears it
        look(7'd1, 32'h1000_0000, "R1");
        fill(7'd1, 20'h10000, 20'hABCDE, 3'b110);
        // R2: hit returns frame and permissions
        look(7'd1, 32'h1000_0ABC, "R2");
        // R12: outstanding miss, hit-under-miss on
        look(7'd2, 32'h1000_0000, "R3");
        look(7'd1, 32'h1000_0000, "R12");
        look(7'd3, 32'h2000_0000, "R12");
        cfg_hum = 1'b0;
        look(7'd1, 32'h1000_0000, "R12");
        fill(7'd2, 20'h10000, 20'h22222, 3'b101);
        look(7'd2, 32'h1000_0FFF, "R3");
        cfg_hum = 1'b1;

        // R4: replacement round-robin and in-place rewrite
        for (int k = 0; k < 7; k++) fill(7'd4, 20'h40000 + 20'(k), 20'h00100 + 20'(k), 3'b100);
        for (int k = 0; k < 7; k++) look(7'd4, va_of(20'h40000 + 20'(k)), "R4");
        fill(7'd4, 20'h40006, 20'h0BEEF, 3'b011);
        look(7'd4, va_of(20'h40006), "R4");

        // R5: active count limits
        cfg_lines = 6'd2;
        for (int k = 0; k < 7; k++) look(7'd4, va_of(20'h40000 + 20'(k)), "R5");
        cfg_lines = 6'd0;
        fill(7'd5, 20'h55555, 20'h55555, 3'b111);
        look(7'd5, va_of(20'h55555), "R5");
        fill(7'd5, 20'h55555, 20'h55555, 3'b111);
        cfg_lines = 6'd63;
        fill(7'd5, 20'h55555, 20'h12345, 3'b111);
        look(7'd5, va_of(20'h55555), "R5");

        // R10: reserved mode keeps everything
        flush(32'h0000_0001);
        look(7'd5, va_of(20'h55555), "R10");
        // R8: section flush
        fill(7'd6, 20'h55400, 20'h00001, 3'b100);
        fill(7'd6, 20'h55800, 20'h00002, 3'b100);
        flush({12'h000, 20'h55555} & 32'h000F_FC00 | 32'h2);
        look(7'd5, va_of(20'h55555), "R8");
        look(7'd6, va_of(20'h55400), "R8");
        look(7'd6, va_of(20'h55800), "R8");
        // R9: group flush with address-space qualifier (R7)
        fill(7'd6, 20'h55804, 20'h00003, 3'b100);
        fill(7'd7, 20'h55801, 20'h00004, 3'b100);
        flush(32'h8000_0000 | (32'(7'd6) << 24) | 32'h0005_5800 | 32'h3);
        look(7'd6, va_of(20'h55800), "R9");
        look(7'd6, va_of(20'h55804), "R9");
        look(7'd7, va_of(20'h55801), "R7");
        // R7: all addresses of one address space
        flush(32'h8000_0000 | (32'(7'd6) << 24));
        look(7'd6, va_of(20'h55804), "R7");
        look(7'd7, va_of(20'h55801), "R7");
        // R11: lookup with flush sees old state; fill with flush survives
        step(1, 7'd7, va_of(20'h55801), 1, 7'd9, 20'h99999, 20'h09999, 3'b010,
             1, 32'h0, "R11");
        look(7'd7, va_of(20'h55801), "R6");
        look(7'd9, va_of(20'h99999), "R11");
        flush(32'h0);
        look(7'd9, va_of(20'h99999), "R6");
        fill(7'd9, 20'h99999, 20'h09999, 3'b010);

        // random phase
        cfg_lines = 6'd6;
        for (int n = 0; n < 1500; n++) begin
            int          op;
            logic [6:0]  a;
            logic [19:0] v;
            logic [31:0] c;
            op = $urandom_range(0, 9);
            a  = 7'($urandom_range(0, 3));
            v  = {2'($urandom_range(0, 1)), 8'h00, 7'h00, 3'($urandom_range(0, 7))};
            if (n == 700) cfg_hum = 1'b0;
            if (n == 1100) cfg_lines = 6'd8;
            if (op < 5) begin
                look(a, va_of(v), "R2");
            end else if (op < 8) begin
                fill(a, v, 20'($urandom), 3'($urandom));
            end else begin
                c = {1'($urandom), a, 4'h0, v} ;
                c[1:0] = 2'($urandom);
                if (op == 9)
                    step(1, a, va_of(v), 0, 0, 0, 0, 0, 1, c, "R11");
                else
                    flush(c);
            end
        end

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: pending responses act=%0d exp=0", sb_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule